// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block is the address-translation core of a game-cartridge controller. The CPU programs it by writing into the upper half of its address space. Each such write lands in one of sixteen 8-bit configuration slots, chosen by address bits 11..8. From the slots that steer something, the block turns the upper CPU address bits into three things: a 4 KB bank number and a device select for the two work RAMs, or an 8 KB bank number and a chip select for the two program ROMs. It also gives the character-RAM page for the lower PPU pattern area and the nametable mirroring choice.

The block sits beside the bus decoder. The memories themselves, any interrupt timer and the nametable storage are outside it. The outputs are combinational from the stored configuration and the incoming address. A new configuration therefore shows on the outputs from the clock edge that accepts the write, and an address change shows in the same cycle.

Only the slots and bits that steer an output are held in flops. These are slots 0 to 5 and bit 1 of slot 10. Data bit 7 never steers anything, so the write-data port is seven bits wide. The design has no sequencing of its own, so there is no state machine. Every path is a window decode followed by a field select.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset every configuration slot reads as zero. An access at 0x8000 gives bank 0 on the internal ROM, an access at 0x6000 gives RAM bank 0 on the main RAM, the lower PPU page is 0 and `mirror_horiz` is 1.
- R2: A write with `cpu_wr` high and address bit 15 set stores the data into slot A[11:8], whatever A[14:12] are. A write below 0x8000 changes no output.
- R3: The CPU window 0x6000-0x6FFF takes its RAM bank from slot 0 and 0x7000-0x7FFF from slot 1. The bank is (s & 1) | (s >> 2) cut to 2 bits, so bank[1] = s[3], bank[0] = s[0] | s[2], and s[1] has no effect.
- R4: In 0x6000-0x7FFF, `ram_cs_main` is high for banks 0 and 1 and `ram_cs_ext` is high for banks 2 and 3. Below 0x6000 no chip select is high.
- R5: The 8 KB windows at 0x8000, 0xA000 and 0xC000 output bits 5..0 of slots 2, 3 and 4 as `prg_bank`.
- R6: In those three windows, bit 6 of the window's slot set to 1 selects the external ROM (`prg_cs_ext`) and 0 selects the internal ROM (`prg_cs_int`). At most one chip select of the four is high at any time.
- R7: The window 0xE000-0xFFFF always gives bank 63 on the external ROM, whatever the slots hold, from reset onward.
- R8: PPU addresses 0x0000-0x0FFF use character page slot5[0] and 0x1000-0x1FFF use page 1. `chr_cs` is high only below 0x2000, and `chr_page` is 0 when it is low.
- R9: `mirror_horiz` is the inverse of bit 1 of slot 10: 1 means horizontal mirroring and 0 means vertical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_hi | input | 8 | CPU address bits 15..8 |
| cpu_wdata | input | 7 | CPU write data bits 6..0 |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr_hi | input | 2 | PPU address bits 13..12 |
| prg_bank | output | 6 | 8 KB program ROM bank |
| prg_cs_int | output | 1 | Internal program ROM select |
| prg_cs_ext | output | 1 | External program ROM select |
| ram_bank | output | 2 | 4 KB RAM bank across both RAMs |
| ram_cs_main | output | 1 | Main-board RAM select |
| ram_cs_ext | output | 1 | Removable battery-backed RAM select |
| chr_cs | output | 1 | Character RAM select |
| chr_page | output | 1 | 4 KB character RAM page |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
A configuration write is due on the outputs from the rising edge that samples `cpu_wr`, because one register stage lies on that path. An address change is due within the same cycle, because no register lies between the address and the outputs. The driver sets the address and write inputs on falling edges and queues the expected outputs. The monitor compares one time unit after the next rising edge, so every sample comes after both kinds of update have settled and long before the next input change.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int NUM_SLOTS    = 16;
    localparam int SLOT_IDX_W   = $clog2(NUM_SLOTS);
    localparam int WDATA_W      = 7;
    localparam int PRG_BANK_W   = 6;
    localparam int PRG_RAW_W    = PRG_BANK_W + 1;
    localparam int PRG_WINS     = 3;
    localparam int RAM_WINS     = 2;
    localparam int RAM_BANK_W   = 2;
    localparam int RAM_RAW_W    = 3;

    localparam int SLOT_RAM_BASE = 0;
    localparam int SLOT_PRG_BASE = 2;
    localparam int SLOT_CHR      = 5;
    localparam int SLOT_MIRR     = 10;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_RAM0,
        WIN_RAM1,
        WIN_PRG0,
        WIN_PRG1,
        WIN_PRG2,
        WIN_PRG_FIX
    } win_e;

    typedef struct packed {
        logic [RAM_WINS-1:0][RAM_RAW_W-1:0] ram_raw;
        logic [PRG_WINS-1:0][PRG_RAW_W-1:0] prg_raw;
        logic                               chr_sel;
        logic                               mirr_bit;
    } cfg_t;

    // raw = {s[3], s[2], s[0]}; bank = (s & 1) | (s >> 2), kept to two bits
    function automatic logic [RAM_BANK_W-1:0] fold_ram(input logic [RAM_RAW_W-1:0] raw);
        return {raw[2], raw[1] | raw[0]};
    endfunction

endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
    import cbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  sel_hi,
    input  logic [SLOT_IDX_W-1:0] idx,
    input  logic [WDATA_W-1:0]    wdata,
    output cfg_t                  cfg
);

    logic hit;
    assign hit = wr_en && sel_hi;

    for (genvar g = 0; g < RAM_WINS; g++) begin : g_ram
        logic [RAM_RAW_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (hit && idx == SLOT_IDX_W'(SLOT_RAM_BASE + g))
                q <= {wdata[3], wdata[2], wdata[0]};
        end
        assign cfg.ram_raw[g] = q;
    end

    for (genvar g = 0; g < PRG_WINS; g++) begin : g_prg
        logic [PRG_RAW_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (hit && idx == SLOT_IDX_W'(SLOT_PRG_BASE + g))
                q <= wdata[PRG_RAW_W-1:0];
        end
        assign cfg.prg_raw[g] = q;
    end

    logic chr_q;
    logic mirr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chr_q  <= 1'b0;
            mirr_q <= 1'b0;
        end else if (hit) begin
            if (idx == SLOT_IDX_W'(SLOT_CHR))
                chr_q <= wdata[0];
            if (idx == SLOT_IDX_W'(SLOT_MIRR))
                mirr_q <= wdata[1];
        end
    end

    assign cfg.chr_sel  = chr_q;
    assign cfg.mirr_bit = mirr_q;

    // R2: without an upper-half write, the configuration holds
    p_hold_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cfg));

    // R5: a write to slot 2 is taken into the first program window field
    p_load_prg0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx == SLOT_IDX_W'(SLOT_PRG_BASE)) |=> (cfg.prg_raw[0] == $past(wdata)));

endmodule

// File: rtl/cbm_cpu_xlate.sv
module cbm_cpu_xlate
    import cbm_pkg::*;
(
    input  logic [3:0]            addr_nib,
    input  cfg_t                  cfg,
    output logic [PRG_BANK_W-1:0] prg_bank,
    output logic                  prg_cs_int,
    output logic                  prg_cs_ext,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_cs_main,
    output logic                  ram_cs_ext
);

    win_e win;

    always_comb begin
        unique case (addr_nib)
            4'h6:        win = WIN_RAM0;
            4'h7:        win = WIN_RAM1;
            4'h8, 4'h9:  win = WIN_PRG0;
            4'hA, 4'hB:  win = WIN_PRG1;
            4'hC, 4'hD:  win = WIN_PRG2;
            4'hE, 4'hF:  win = WIN_PRG_FIX;
            default:     win = WIN_NONE;
        endcase
    end

    logic [PRG_RAW_W-1:0] prg_raw_sel;
    logic [RAM_BANK_W-1:0] ram_fold;

    always_comb begin
        prg_bank    = '0;
        prg_cs_int  = 1'b0;
        prg_cs_ext  = 1'b0;
        ram_bank    = '0;
        ram_cs_main = 1'b0;
        ram_cs_ext  = 1'b0;
        prg_raw_sel = '0;
        ram_fold    = '0;
        unique case (win)
            WIN_RAM0, WIN_RAM1: begin
                ram_fold    = fold_ram(cfg.ram_raw[(win == WIN_RAM1) ? 1 : 0]);
                ram_bank    = ram_fold;
                ram_cs_ext  = ram_fold[RAM_BANK_W-1];
                ram_cs_main = !ram_fold[RAM_BANK_W-1];
            end
            WIN_PRG0, WIN_PRG1, WIN_PRG2: begin
                if (win == WIN_PRG0)
                    prg_raw_sel = cfg.prg_raw[0];
                else if (win == WIN_PRG1)
                    prg_raw_sel = cfg.prg_raw[1];
                else
                    prg_raw_sel = cfg.prg_raw[2];
                prg_bank   = prg_raw_sel[PRG_BANK_W-1:0];
                prg_cs_ext = prg_raw_sel[PRG_BANK_W];
                prg_cs_int = !prg_raw_sel[PRG_BANK_W];
            end
            WIN_PRG_FIX: begin
                prg_bank   = '1;
                prg_cs_ext = 1'b1;
            end
            WIN_NONE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cbm_ppu_xlate.sv
module cbm_ppu_xlate (
    input  logic [1:0] ppu_hi,
    input  logic       chr_sel,
    output logic       chr_cs,
    output logic       chr_page
);

    always_comb begin
        chr_cs   = 1'b0;
        chr_page = 1'b0;
        unique case (ppu_hi)
            2'b00: begin
                chr_cs   = 1'b1;
                chr_page = chr_sel;
            end
            2'b01: begin
                chr_cs   = 1'b1;
                chr_page = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            cpu_addr_hi,
    input  logic [WDATA_W-1:0]    cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [1:0]            ppu_addr_hi,
    output logic [PRG_BANK_W-1:0] prg_bank,
    output logic                  prg_cs_int,
    output logic                  prg_cs_ext,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_cs_main,
    output logic                  ram_cs_ext,
    output logic                  chr_cs,
    output logic                  chr_page,
    output logic                  mirror_horiz
);

    cfg_t cfg;

    cbm_regfile u_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr),
        .sel_hi (cpu_addr_hi[7]),
        .idx    (cpu_addr_hi[3:0]),
        .wdata  (cpu_wdata),
        .cfg    (cfg)
    );

    cbm_cpu_xlate u_cpu_xlate (
        .addr_nib    (cpu_addr_hi[7:4]),
        .cfg         (cfg),
        .prg_bank    (prg_bank),
        .prg_cs_int  (prg_cs_int),
        .prg_cs_ext  (prg_cs_ext),
        .ram_bank    (ram_bank),
        .ram_cs_main (ram_cs_main),
        .ram_cs_ext  (ram_cs_ext)
    );

    cbm_ppu_xlate u_ppu_xlate (
        .ppu_hi   (ppu_addr_hi),
        .chr_sel  (cfg.chr_sel),
        .chr_cs   (chr_cs),
        .chr_page (chr_page)
    );

    assign mirror_horiz = !cfg.mirr_bit;

    // R6: never more than one memory device selected
    p_cs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prg_cs_int, prg_cs_ext, ram_cs_main, ram_cs_ext}));

    // R7: top window is the last external bank
    p_fixed_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_hi[7:5] == 3'b111) |-> (prg_cs_ext && prg_bank == '1));

    // R4: nothing selected below the RAM windows
    p_no_cs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_hi < 8'h60) |-> !(prg_cs_int || prg_cs_ext || ram_cs_main || ram_cs_ext));

    // R8: upper pattern page is fixed to page 1
    p_chr_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr_hi == 2'b01) |-> (chr_cs && chr_page));

    // R9: a slot-10 write sets mirroring to the inverse of data bit 1
    p_mirror_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_hi[7] && cpu_addr_hi[3:0] == 4'hA)
            |=> (mirror_horiz == !$past(cpu_wdata[1])));

endmodule

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr_hi = 8'h00;
    logic [6:0] cpu_wdata = 7'h00;
    logic       cpu_wr = 1'b0;
    logic [1:0] ppu_addr_hi = 2'b11;
    logic [5:0] prg_bank;
    logic       prg_cs_int, prg_cs_ext;
    logic [1:0] ram_bank;
    logic       ram_cs_main, ram_cs_ext;
    logic       chr_cs, chr_page, mirror_horiz;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cart_bank_mapper u_cart_bank_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr_hi  (cpu_addr_hi),
        .cpu_wdata    (cpu_wdata),
        .cpu_wr       (cpu_wr),
        .ppu_addr_hi  (ppu_addr_hi),
        .prg_bank     (prg_bank),
        .prg_cs_int   (prg_cs_int),
        .prg_cs_ext   (prg_cs_ext),
        .ram_bank     (ram_bank),
        .ram_cs_main  (ram_cs_main),
        .ram_cs_ext   (ram_cs_ext),
        .chr_cs       (chr_cs),
        .chr_page     (chr_page),
        .mirror_horiz (mirror_horiz)
    );

    typedef struct {
        logic [14:0] exp;
        string       tag;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] shadow [16];
    int         checks = 0;
    int         failures = 0;
    bit         finished = 0;

    function automatic logic [14:0] model(input logic [15:0] ca, input logic [13:0] pa);
        logic [5:0] pb = '0;
        logic pi = 0, pe = 0, rm = 0, re = 0, cc = 0, cp = 0;
        logic [1:0] rb = '0;
        logic [7:0] s;
        int w;
        if (ca >= 16'hE000) begin
            pb = 6'd63; pe = 1;
        end else if (ca >= 16'h8000) begin
            w = 2 + int'(ca[14:13]);
            s = shadow[w];
            pb = s[5:0]; pe = s[6]; pi = !s[6];
        end else if (ca >= 16'h6000) begin
            s = shadow[ca[12] ? 1 : 0];
            rb = 2'(((s & 8'h01) | (s >> 2)) & 8'h03);
            rm = (rb < 2); re = (rb >= 2);
        end
        if (pa < 14'h2000) begin
            cc = 1;
            cp = pa[12] ? 1'b1 : shadow[5][0];
        end
        return {pb, pi, pe, rb, rm, re, cc, cp, !shadow[10][1]};
    endfunction

    task automatic write_slot(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr_hi = a[15:8];
        cpu_wdata   = d[6:0];
        cpu_wr      = 1'b1;
        if (a[15]) shadow[a[11:8]] = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] ca, input logic [13:0] pa, input string tag);
        item_t it;
        @(negedge clk);
        cpu_addr_hi = ca[15:8];
        ppu_addr_hi = pa[13:12];
        it.exp = model(ca, pa);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [14:0] act;
                it  = sb_q.pop_front();
                act = {prg_bank, prg_cs_int, prg_cs_ext, ram_bank, ram_cs_main,
                       ram_cs_ext, chr_cs, chr_page, mirror_horiz};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(16'h8000, 14'h0000, "R1");
        probe(16'h6000, 14'h3000, "R1");
        // R7: fixed window right after reset
        probe(16'hE000, 14'h1000, "R7");

        // R5/R6: three switchable program windows, both chip choices
        write_slot(16'h8200, 8'h45);
        write_slot(16'h8300, 8'h2A);
        write_slot(16'h8400, 8'h7F);
        probe(16'h8100, 14'h3000, "R5");
        probe(16'hA000, 14'h3000, "R5");
        probe(16'hC800, 14'h3000, "R6");
        // R7: fixed window ignores slot contents
        probe(16'hFF00, 14'h3000, "R7");

        // R2: upper address bits 14..12 do not change the slot
        write_slot(16'hF200, 8'h13);
        probe(16'h9000, 14'h3000, "R2");
        // R2: write below 0x8000 is ignored
        write_slot(16'h6200, 8'h55);
        probe(16'h8000, 14'h3000, "R2");

        // R3/R4: RAM bank folding and device select
        write_slot(16'h8000, 8'h04);
        write_slot(16'h8100, 8'h08);
        probe(16'h6000, 14'h3000, "R3");
        probe(16'h7F00, 14'h3000, "R4");
        write_slot(16'h8000, 8'h09);
        write_slot(16'h8100, 8'h01);
        probe(16'h6A00, 14'h3000, "R4");
        probe(16'h7000, 14'h3000, "R3");
        write_slot(16'h8000, 8'h02);
        probe(16'h6000, 14'h3000, "R3");
        // R4: no select below 0x6000
        probe(16'h5000, 14'h3000, "R4");

        // R8: character pages
        write_slot(16'h8500, 8'h01);
        probe(16'h5000, 14'h0000, "R8");
        probe(16'h5000, 14'h1F00, "R8");
        write_slot(16'h8500, 8'h00);
        probe(16'h5000, 14'h0A00, "R8");
        probe(16'h5000, 14'h2000, "R8");

        // R9: mirroring
        write_slot(16'h8A00, 8'h02);
        probe(16'h5000, 14'h3000, "R9");
        write_slot(16'h8A00, 8'h7D);
        probe(16'h5000, 14'h3000, "R9");

        repeat (4) @(posedge clk);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule